// File: doc/BRIEF.md
# Smart-card T0 half-duplex character transceiver

This block moves 8-bit characters over a single open-drain line shared with a smart card, in the character-level T0 style. The line is only ever pulled low or released, and a pull-up gives the high level. A character starts with a low start bit, then eight data bits LSB first and an even-parity bit, each 16 baud ticks long. It ends with a 24-tick guard period in which neither side sends data.

The guard period carries error signalling. When the block receives a character whose parity is wrong, it pulls the line low for one bit time in the middle of the guard period. When the block is the sender, it releases the line for the whole guard period and samples it in the middle of that period. A low level there is a NAK from the far end. With auto-retry enabled, the same byte is sent again after a short gap, up to three times. Receiver and transmitter share one state machine, so the block is either sending or receiving, never both.

Top module: `iso7816_t0_xcvr`

## Requirements
- R1: After reset the line is released (lineDriveLow=0), and txBusy, rxValid and nakSeen are 0.
- R2: An accepted transmit sends a frame on the line: a start bit at level 0, then txByte bit 0 first through bit 7, then a parity bit equal to the XOR of the 8 data bits (even parity). Each bit lasts 16 baudTick pulses, and the line is pulled low only for bits of value 0.
- R3: The transmitter never pulls the line low during the guard period, during the retry gap or while idle.
- R4: During its own guard period the transmitter samples the line at guard tick 16. A low level there gives a one-cycle pulse on nakSeen.
- R5: With autoRetry=1, a NAKed byte is sent again after a 16-tick gap, at most 3 times (4 frames in total). With autoRetry=0, a NAK ends the transfer with no resend.
- R6: A received frame gives a one-cycle rxValid pulse after the 24-tick guard period. At that pulse rxData holds the 8 data bits and rxParityErr is 1 if the data bits and the parity bit together hold an odd number of ones.
- R7: On a received parity error, the block pulls the line low from guard tick 8 to guard tick 24 (16 ticks). On good parity it leaves the line released.
- R8: A low pulse that is already high again at the middle of the start bit (tick 8) is discarded: no rxValid and no NAK follow.
- R9: txReq is ignored while a transmission is in progress and while a character is being received.
- R10: txBusy goes high the cycle after an accepted txReq. It stays high through all retries and falls at the end of the last guard period, with the line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse, 16 per bit time |
| lineIn | input | 1 | Level read back from the shared line |
| lineDriveLow | output | 1 | 1 pulls the shared line low; 0 releases it |
| txReq | input | 1 | Request to send txByte (taken only when idle) |
| txByte | input | 8 | Byte to send |
| autoRetry | input | 1 | Resend a NAKed byte, up to 3 times |
| txBusy | output | 1 | Transmission (including retries) in progress |
| rxValid | output | 1 | One-cycle pulse: received character ready |
| rxData | output | 8 | Received data byte |
| rxParityErr | output | 1 | Received character failed the even-parity check |
| nakSeen | output | 1 | One-cycle pulse: NAK detected in the transmit guard period |

## Verification
The transmit path is tried with alternating, all-zero and all-one bytes, so that bit order and the parity level can be told apart from a stuck line. The NAK schedules are: none, NAK on the first frame only, NAK on every frame with retry enabled, and a single NAK with retry disabled. These separate the resend count and the give-up point from plain NAK detection, measured both through nakSeen pulses and through how long txBusy stays high. The receive path gets bytes with good and with forced-bad parity, and the line level is checked before, inside and after the NAK window. A short start glitch and a transmit request issued in the middle of a reception show that false starts and requests at the wrong time leave no trace.

// File: rtl/t0_pkg.sv
package t0_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TX_BITS,
    S_TX_GUARD,
    S_TX_GAP,
    S_RX_BITS,
    S_RX_GUARD
  } xcvrState_e;

  // Strobes from control to datapath, one cycle each unless a level
  typedef struct packed {
    logic loadFrame;
    logic clrTick;
    logic incTick;
    logic clrBit;
    logic incBit;
    logic sampleRx;
    logic clrRetry;
    logic incRetry;
    logic clrNak;
    logic setNak;
    logic driveLow;
    logic rxDone;
    logic nakPulse;
  } ctrlStrobe_t;

endpackage

// File: rtl/t0_datapath.sv
module t0_datapath
  import t0_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int TICK_W    = 5,
  parameter int BIT_W     = 4,
  parameter int RETRY_W   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineIn,
  input  logic [DATA_BITS-1:0] txByte,
  input  ctrlStrobe_t          strobe,
  output logic [TICK_W-1:0]    tickCnt,
  output logic [BIT_W-1:0]     bitIdx,
  output logic                 txBit,
  output logic                 lineSync,
  output logic                 lineFell,
  output logic [RETRY_W-1:0]   retryCnt,
  output logic                 nakLatched,
  output logic                 rxParErr,
  output logic                 lineDriveLow,
  output logic                 rxValid,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxParityErr,
  output logic                 nakSeen
);

  localparam int FRAME_BITS = DATA_BITS + 2;

  logic [FRAME_BITS-1:0] txFrame;
  logic [DATA_BITS:0]    rxShift;
  logic                  lineMeta;
  logic                  linePrev;

  // Two-flop synchronizer plus edge detector; idle level is high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineMeta <= 1'b1;
      lineSync <= 1'b1;
      linePrev <= 1'b1;
    end else begin
      lineMeta <= lineIn;
      lineSync <= lineMeta;
      linePrev <= lineSync;
    end
  end

  assign lineFell = linePrev && !lineSync;

  always_ff @(posedge clk) begin
    if (!rstN) tickCnt <= '0;
    else if (strobe.clrTick) tickCnt <= '0;
    else if (strobe.incTick) tickCnt <= tickCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) bitIdx <= '0;
    else if (strobe.clrBit) bitIdx <= '0;
    else if (strobe.incBit) bitIdx <= bitIdx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) retryCnt <= '0;
    else if (strobe.clrRetry) retryCnt <= '0;
    else if (strobe.incRetry) retryCnt <= retryCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) nakLatched <= 1'b0;
    else if (strobe.clrNak) nakLatched <= 1'b0;
    else if (strobe.setNak) nakLatched <= 1'b1;
  end

  // Frame: {even parity, data LSB first, start=0}
  always_ff @(posedge clk) begin
    if (!rstN) txFrame <= '1;
    else if (strobe.loadFrame) txFrame <= {^txByte, txByte, 1'b0};
  end

  assign txBit = txFrame[bitIdx];

  always_ff @(posedge clk) begin
    if (!rstN) rxShift <= '0;
    else if (strobe.sampleRx) rxShift <= {lineSync, rxShift[DATA_BITS:1]};
  end

  assign rxParErr = ^rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineDriveLow <= 1'b0;
      rxValid      <= 1'b0;
      rxData       <= '0;
      rxParityErr  <= 1'b0;
      nakSeen      <= 1'b0;
    end else begin
      lineDriveLow <= strobe.driveLow;
      rxValid      <= strobe.rxDone;
      nakSeen      <= strobe.nakPulse;
      if (strobe.rxDone) begin
        rxData      <= rxShift[DATA_BITS-1:0];
        rxParityErr <= rxParErr;
      end
    end
  end

  // R3: the frame register only changes while no bit is being driven
  a_r3_frame_stable: assert property (@(posedge clk) disable iff (!rstN)
    strobe.driveLow |=> $stable(txFrame) || $past(strobe.loadFrame));

endmodule

// File: rtl/t0_ctrl.sv
module t0_ctrl
  import t0_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int GUARD_TICKS = 24,
  parameter int NAK_START   = 8,
  parameter int NAK_END     = 24,
  parameter int GAP_TICKS   = 16,
  parameter int MAX_RETRY   = 3,
  parameter int FRAME_BITS  = 10,
  parameter int TICK_W      = 5,
  parameter int BIT_W       = 4,
  parameter int RETRY_W     = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baudTick,
  input  logic               txReq,
  input  logic               autoRetry,
  input  logic [TICK_W-1:0]  tickCnt,
  input  logic [BIT_W-1:0]   bitIdx,
  input  logic               txBit,
  input  logic               lineSync,
  input  logic               lineFell,
  input  logic [RETRY_W-1:0] retryCnt,
  input  logic               nakLatched,
  input  logic               rxParErr,
  output ctrlStrobe_t        strobe,
  output logic               txBusy
);

  localparam logic [TICK_W-1:0]  HALF_TICK    = TICK_W'(OVERSAMPLE / 2 - 1);
  localparam logic [TICK_W-1:0]  BIT_END      = TICK_W'(OVERSAMPLE - 1);
  localparam logic [TICK_W-1:0]  GUARD_END    = TICK_W'(GUARD_TICKS - 1);
  localparam logic [TICK_W-1:0]  GUARD_SAMPLE = TICK_W'((NAK_START + NAK_END) / 2);
  localparam logic [TICK_W-1:0]  NAK_LO       = TICK_W'(NAK_START);
  localparam logic [TICK_W-1:0]  NAK_HI       = TICK_W'(NAK_END);
  localparam logic [TICK_W-1:0]  GAP_END      = TICK_W'(GAP_TICKS - 1);
  localparam logic [BIT_W-1:0]   LAST_BIT     = BIT_W'(FRAME_BITS - 1);
  localparam logic [RETRY_W-1:0] RETRY_LIMIT  = RETRY_W'(MAX_RETRY);

  xcvrState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (txReq) begin
          strobe.loadFrame = 1'b1;
          strobe.clrTick   = 1'b1;
          strobe.clrBit    = 1'b1;
          strobe.clrRetry  = 1'b1;
          strobe.clrNak    = 1'b1;
          nextState        = S_TX_BITS;
        end else if (lineFell) begin
          strobe.clrTick = 1'b1;
          strobe.clrBit  = 1'b1;
          nextState      = S_RX_BITS;
        end
      end
      S_TX_BITS: begin
        strobe.driveLow = !txBit;
        if (baudTick) begin
          if (tickCnt == BIT_END) begin
            strobe.clrTick = 1'b1;
            if (bitIdx == LAST_BIT) nextState = S_TX_GUARD;
            else strobe.incBit = 1'b1;
          end else begin
            strobe.incTick = 1'b1;
          end
        end
      end
      S_TX_GUARD: begin
        if (baudTick) begin
          if (tickCnt == GUARD_SAMPLE && !lineSync) begin
            strobe.setNak   = 1'b1;
            strobe.nakPulse = 1'b1;
          end
          if (tickCnt == GUARD_END) begin
            strobe.clrTick = 1'b1;
            if (nakLatched && autoRetry && retryCnt < RETRY_LIMIT) begin
              strobe.incRetry = 1'b1;
              nextState       = S_TX_GAP;
            end else begin
              nextState = S_IDLE;
            end
          end else begin
            strobe.incTick = 1'b1;
          end
        end
      end
      S_TX_GAP: begin
        if (baudTick) begin
          if (tickCnt == GAP_END) begin
            strobe.clrTick = 1'b1;
            strobe.clrBit  = 1'b1;
            strobe.clrNak  = 1'b1;
            nextState      = S_TX_BITS;
          end else begin
            strobe.incTick = 1'b1;
          end
        end
      end
      S_RX_BITS: begin
        if (baudTick) begin
          if (tickCnt == HALF_TICK && bitIdx == '0 && lineSync) begin
            strobe.clrTick = 1'b1;           // false start
            nextState      = S_IDLE;
          end else begin
            if (tickCnt == HALF_TICK && bitIdx != '0) strobe.sampleRx = 1'b1;
            if (tickCnt == BIT_END) begin
              strobe.clrTick = 1'b1;
              if (bitIdx == LAST_BIT) nextState = S_RX_GUARD;
              else strobe.incBit = 1'b1;
            end else begin
              strobe.incTick = 1'b1;
            end
          end
        end
      end
      S_RX_GUARD: begin
        strobe.driveLow = rxParErr && (tickCnt >= NAK_LO) && (tickCnt < NAK_HI);
        if (baudTick) begin
          if (tickCnt == GUARD_END) begin
            strobe.rxDone  = 1'b1;
            strobe.clrTick = 1'b1;
            nextState      = S_IDLE;
          end else begin
            strobe.incTick = 1'b1;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign txBusy = (state == S_TX_BITS) || (state == S_TX_GUARD) || (state == S_TX_GAP);

  // R5: a retry gap is only ever entered after a NAK was latched
  a_r5_gap_needs_nak: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TX_GAP) |-> nakLatched);

  // R9: a request during reception does not start a transmission
  a_r9_rx_blocks_tx: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RX_BITS) |=> (state != S_TX_BITS));

endmodule

// File: rtl/iso7816_t0_xcvr.sv
module iso7816_t0_xcvr
  import t0_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int GUARD_TICKS = 24,
  parameter int NAK_START   = 8,
  parameter int NAK_END     = 24,
  parameter int GAP_TICKS   = 16,
  parameter int MAX_RETRY   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic                 lineIn,
  output logic                 lineDriveLow,
  input  logic                 txReq,
  input  logic [DATA_BITS-1:0] txByte,
  input  logic                 autoRetry,
  output logic                 txBusy,
  output logic                 rxValid,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxParityErr,
  output logic                 nakSeen
);

  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int CNT_A      = (OVERSAMPLE > GUARD_TICKS) ? OVERSAMPLE : GUARD_TICKS;
  localparam int CNT_B      = (GAP_TICKS > NAK_END) ? GAP_TICKS : NAK_END;
  localparam int CNT_MAX    = (CNT_A > CNT_B) ? CNT_A : CNT_B;
  localparam int TICK_W     = $clog2(CNT_MAX + 1);
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int RETRY_W    = $clog2(MAX_RETRY + 1);

  ctrlStrobe_t        strobe;
  logic [TICK_W-1:0]  tickCnt;
  logic [BIT_W-1:0]   bitIdx;
  logic [RETRY_W-1:0] retryCnt;
  logic               txBit, lineSync, lineFell, nakLatched, rxParErr;

  t0_ctrl #(
    .OVERSAMPLE(OVERSAMPLE), .GUARD_TICKS(GUARD_TICKS), .NAK_START(NAK_START),
    .NAK_END(NAK_END), .GAP_TICKS(GAP_TICKS), .MAX_RETRY(MAX_RETRY),
    .FRAME_BITS(FRAME_BITS), .TICK_W(TICK_W), .BIT_W(BIT_W), .RETRY_W(RETRY_W)
  ) u_ctrl (
    .clk, .rstN, .baudTick, .txReq, .autoRetry,
    .tickCnt, .bitIdx, .txBit, .lineSync, .lineFell, .retryCnt,
    .nakLatched, .rxParErr, .strobe, .txBusy
  );

  t0_datapath #(
    .DATA_BITS(DATA_BITS), .TICK_W(TICK_W), .BIT_W(BIT_W), .RETRY_W(RETRY_W)
  ) u_dp (
    .clk, .rstN, .lineIn, .txByte, .strobe,
    .tickCnt, .bitIdx, .txBit, .lineSync, .lineFell, .retryCnt,
    .nakLatched, .rxParErr, .lineDriveLow, .rxValid, .rxData,
    .rxParityErr, .nakSeen
  );

  // R4: NAK detection belongs to a transmission and lasts one cycle
  a_r4_nak_in_tx: assert property (@(posedge clk) disable iff (!rstN)
    nakSeen |-> txBusy);
  a_r4_nak_pulse: assert property (@(posedge clk) disable iff (!rstN)
    nakSeen |=> !nakSeen);

  // R6: received characters arrive as single pulses, never during transmit
  a_r6_rx_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  a_r6_rx_not_tx: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !txBusy);

  // R10: end of transmission leaves the line released
  a_r10_release_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBusy) |-> !lineDriveLow);

endmodule

// File: tb/iso7816_t0_xcvr_bench.sv
module iso7816_t0_xcvr_bench;

  typedef struct {
    logic [7:0] data;
    logic       flag;
  } item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       txReq = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic       autoRetry = 1'b0;
  logic       cardDrive = 1'b0;
  logic       lineIn;
  logic       lineDriveLow, txBusy, rxValid, rxParityErr, nakSeen;
  logic [7:0] rxData;

  int total = 0;
  int bad = 0;
  int nakCnt = 0;
  int rxCount = 0;
  int busyTicks = 0;
  int divCnt = 0;

  item_t rxQ[$];
  item_t txQ[$];
  item_t rItem;
  item_t tItem;

  always #10 clk = ~clk;

  assign lineIn = !(lineDriveLow || cardDrive);

  iso7816_t0_xcvr u_iso7816_t0_xcvr (
    .clk, .rstN, .baudTick, .lineIn, .lineDriveLow, .txReq, .txByte,
    .autoRetry, .txBusy, .rxValid, .rxData, .rxParityErr, .nakSeen
  );

  always @(negedge clk) begin
    divCnt   <= (divCnt == 3) ? 0 : divCnt + 1;
    baudTick <= (divCnt == 3);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!baudTick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  // Monitors
  always @(negedge clk) begin
    if (rstN && nakSeen) nakCnt++;
    if (rstN && txBusy && baudTick) busyTicks++;
    if (rstN && rxValid) begin
      rxCount++;
      if (rxQ.size() == 0) begin
        chk(1'b0, "R8 unexpected rxValid", rxData, 0);
      end else begin
        rItem = rxQ.pop_front();
        chk(rxData == rItem.data, "R6 rxData", rxData, rItem.data);
        chk(rxParityErr == rItem.flag, "R6 rxParityErr", rxParityErr, rItem.flag);
      end
    end
  end

  // Card-side receiver: decodes frames sent by the block, NAKs on request
  initial begin
    logic [7:0] got;
    logic       par;
    forever begin
      wait (txQ.size() > 0);
      @(negedge lineIn);
      waitTicks(8);
      chk(lineIn == 1'b0, "R2 start bit", lineIn, 0);
      for (int i = 0; i < 8; i++) begin
        waitTicks(16);
        got[i] = lineIn;
      end
      waitTicks(16);
      par = lineIn;
      tItem = txQ.pop_front();
      chk(got == tItem.data, "R2 tx data", got, tItem.data);
      chk(par == ^tItem.data, "R2 even parity", par, ^tItem.data);
      waitTicks(12);
      chk(lineDriveLow == 1'b0, "R3 released in guard", lineDriveLow, 0);
      waitTicks(4);
      if (tItem.flag) begin
        cardDrive = 1'b1;
        waitTicks(16);
        cardDrive = 1'b0;
      end else begin
        waitTicks(12);
        chk(lineDriveLow == 1'b0, "R3 released late guard", lineDriveLow, 0);
      end
    end
  end

  task automatic dutSend(input logic [7:0] b, input int frames, input int naks,
                         input bit retry, input bit poke, input string tag);
    int startNak;
    int expTicks;
    int diff;
    for (int i = 0; i < frames; i++) txQ.push_back('{data: b, flag: (i < naks)});
    autoRetry = retry;
    @(negedge clk);
    txByte = b;
    txReq = 1'b1;
    startNak = nakCnt;
    busyTicks = 0;
    @(negedge clk);
    txReq = 1'b0;
    chk(txBusy == 1'b1, {"R10 busy after request ", tag}, txBusy, 1);
    if (poke) begin
      waitTicks(20);
      txByte = 8'hFF;
      txReq = 1'b1;
      @(negedge clk);
      txReq = 1'b0;
    end
    while (txBusy) @(negedge clk);
    chk(lineDriveLow == 1'b0, {"R10 line released at end ", tag}, lineDriveLow, 0);
    waitTicks(40);
    chk(txBusy == 1'b0, {"R9 no extra transmission ", tag}, txBusy, 0);
    chk(txQ.size() == 0, {"R5 frame count ", tag}, txQ.size(), 0);
    chk(nakCnt - startNak == naks, {"R4 nakSeen count ", tag}, nakCnt - startNak, naks);
    expTicks = frames * 184 + (frames - 1) * 16;
    diff = busyTicks - expTicks;
    chk(diff <= 2 && diff >= -2, {"R5 busy duration ", tag}, busyTicks, expTicks);
  endtask

  task automatic cardSend(input logic [7:0] b, input bit badPar, input bit poke,
                          input string tag);
    logic [9:0] frame;
    frame = {(^b) ^ badPar, b, 1'b0};
    rxQ.push_back('{data: b, flag: badPar});
    for (int i = 0; i < 10; i++) begin
      cardDrive = !frame[i];
      if (poke && i == 4) begin
        waitTicks(8);
        txByte = 8'h55;
        txReq = 1'b1;
        @(negedge clk);
        txReq = 1'b0;
        @(negedge clk);
        chk(txBusy == 1'b0, {"R9 request ignored during rx ", tag}, txBusy, 0);
        waitTicks(8);
      end else begin
        waitTicks(16);
      end
    end
    cardDrive = 1'b0;
    waitTicks(4);
    chk(lineIn == 1'b1, {"R7 no early NAK ", tag}, lineIn, 1);
    waitTicks(12);
    chk(lineIn == !badPar, {"R7 NAK level mid guard ", tag}, lineIn, !badPar);
    waitTicks(12);
    chk(lineIn == 1'b1, {"R7 NAK released ", tag}, lineIn, 1);
    waitTicks(12);
    chk(rxQ.size() == 0, {"R6 character delivered ", tag}, rxQ.size(), 0);
  endtask

  initial begin
    int c;
    repeat (4) @(negedge clk);
    chk(lineDriveLow == 1'b0, "R1 reset drive", lineDriveLow, 0);
    chk(txBusy == 1'b0, "R1 reset busy", txBusy, 0);
    chk(rxValid == 1'b0, "R1 reset rxValid", rxValid, 0);
    chk(nakSeen == 1'b0, "R1 reset nakSeen", nakSeen, 0);
    rstN = 1'b1;
    waitTicks(20);

    // Transmit direction
    dutSend(8'hA5, 1, 0, 1'b1, 1'b0, "clean");
    dutSend(8'h3C, 2, 1, 1'b1, 1'b0, "one nak");
    dutSend(8'h81, 4, 4, 1'b1, 1'b0, "retry exhausted");
    dutSend(8'h5A, 1, 1, 1'b0, 1'b0, "no retry");
    dutSend(8'h00, 1, 0, 1'b0, 1'b0, "zeros");
    dutSend(8'hFF, 1, 0, 1'b0, 1'b0, "ones");
    dutSend(8'h96, 1, 0, 1'b1, 1'b1, "request while busy");

    // Receive direction
    cardSend(8'h96, 1'b0, 1'b0, "good");
    cardSend(8'h6B, 1'b1, 1'b0, "bad parity");
    cardSend(8'h00, 1'b0, 1'b0, "zeros");
    cardSend(8'hFF, 1'b1, 1'b0, "ones bad parity");

    // R8: start glitch
    c = rxCount;
    cardDrive = 1'b1;
    waitTicks(3);
    cardDrive = 1'b0;
    waitTicks(40);
    chk(rxCount == c, "R8 glitch gives no character", rxCount, c);
    chk(lineIn == 1'b1, "R8 glitch gives no NAK", lineIn, 1);

    cardSend(8'hC3, 1'b0, 1'b1, "poke during rx");
    waitTicks(10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule